// File: doc/BRIEF.md
# Serial Port Register Front End with Prioritised Interrupt

This block is the bus-facing register file of a classic 16550-style serial port. It decodes word-aligned 32-bit reads and writes into eight word slots. The word index is the byte address shifted right by two, and only accesses with the two low address bits at zero and no address bits set above bit 4 are decoded. The block holds the last received character and the line status and modem status flags. It detects a receive overrun without any receive queue. It keeps the interrupt enable, line control, modem control and divisor settings and drives them out to the serializer and baud logic.

One level-sensitive interrupt line is produced by a fixed four-level priority encoder. The encoder also supplies the identification code read back by software. On the device side the block accepts one character per pulse from a deserializer, together with per-character error flags. It emits a one-cycle transmit pulse carrying the written byte. It follows two transmitter status inputs and four sampled modem line inputs.

Top module: `serial_regfile`

## Requirements
- R1: After reset the line status word (index 5) reads 0x60, the identification word (index 2) reads 0x01, the data word (index 0) and the modem status word (index 6) read 0, `irq` is low and `rx_ready` is high.
- R2: A read of the data word returns the held character in bits 7:0 and clears the data-ready flag (line status bit 0) at the end of that cycle, unless a character arrives in the same cycle.
- R3: A character arriving while data-ready is set and no data read happens in that cycle sets the overrun flag (bit 1), replaces the held character, and leaves data-ready set. A character arriving in the same cycle as a data read sets no overrun.
- R4: `rx_ready` is high exactly when data-ready is clear, and it changes in the cycle after the event that changes data-ready.
- R5: The enable word (index 1; bit 0 receive data, bit 1 transmit holding empty, bit 2 line error, bit 3 modem change), the line control word (index 3), the modem control word (index 4) and the divisor word (index 7) are write-only: they read 0, and their written values appear on `cfg_lcr`, `cfg_mcr` (bits 1:0) and `cfg_div` from the next cycle.
- R6: Writes to the identification, line status and modem status words leave their read values unchanged.
- R7: A write to the data word produces `tx_valid` high for exactly the following cycle, with `tx_byte` equal to write data bits 7:0.
- R8: Interrupt causes are ranked, highest first: any line error flag with enable bit 2 (code 0b110); data-ready with enable bit 0 (0b100); transmit holding empty with enable bit 1 (0b010); any modem delta flag with enable bit 3 (0b000). With no cause the code is 0b001 and `irq` is low. Otherwise `irq` is high. Both follow the state in the cycle after it changes.
- R9: The parity (bit 2), framing (bit 3) and break (bit 4) flags are set from `rx_perr`, `rx_ferr` and `rx_brk` when a character arrives. They and the overrun flag stay set until a line status read clears them. A flag raised in the same cycle as that read survives it.
- R10: The modem status word carries the line states CTS, DSR, RI and DCD in bits 4 to 7 from `modem_lines[0..3]`. Bits 0, 1 and 3 set on any change of CTS, DSR and DCD. Bit 2 sets only when RI falls. A modem status read clears bits 3:0.
- R11: Line status bit 5 follows `tx_hold_empty` and bit 6 follows `tx_line_idle`, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| rx_valid | input | 1 | One character arrives this cycle |
| rx_byte | input | 8 | Arriving character |
| rx_perr | input | 1 | Parity error for the arriving character |
| rx_ferr | input | 1 | Framing error for the arriving character |
| rx_brk | input | 1 | Break seen with the arriving character |
| rx_ready | output | 1 | Holder is free for a new character |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_byte | output | 8 | Byte to transmit |
| tx_hold_empty | input | 1 | Transmitter can take a byte |
| tx_line_idle | input | 1 | Transmitter shift path is empty |
| modem_lines | input | 4 | Sampled CTS, DSR, RI, DCD (bits 0 to 3) |
| cfg_lcr | output | 8 | Line control setting |
| cfg_mcr | output | 2 | Modem control setting |
| cfg_div | output | DIV_W | Baud divisor setting |
| irq | output | 1 | Level interrupt request |

## Verification
The block's read side effects race against incoming events. A data read can fall in the same cycle as a new character. A line status read can fall in the same cycle as a character that carries an error flag. The bench provokes each case by driving the read strobe and the character pulse in the same cycle. The scoreboard expects the pre-edge value on the read data. The follow-up reads must then show the new character with data-ready set and no overrun, or the freshly raised error flag still set. The interrupt ranking is judged by stacking causes and removing them one at a time, reading the identification code after each step.

// File: rtl/serial_regfile_pkg.sv
package serial_regfile_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned CHAR_W = 8;
   localparam int unsigned MDM_N  = 4;

   typedef enum logic [2:0] {
      W_DATA  = 3'd0,
      W_IEN   = 3'd1,
      W_IID   = 3'd2,
      W_LCTL  = 3'd3,
      W_MCTL  = 3'd4,
      W_LSTAT = 3'd5,
      W_MSTAT = 3'd6,
      W_DIV   = 3'd7
   } word_e;

   typedef enum logic [2:0] {
      ID_LINE = 3'b110,
      ID_RXD  = 3'b100,
      ID_THR  = 3'b010,
      ID_MDM  = 3'b000,
      ID_NONE = 3'b001
   } iid_e;

   // enable word bit positions
   localparam int unsigned EN_RXD  = 0;
   localparam int unsigned EN_THR  = 1;
   localparam int unsigned EN_LINE = 2;
   localparam int unsigned EN_MDM  = 3;

   // index of the ring line inside the modem vector
   localparam int unsigned RING_IDX = 2;

endpackage

// File: rtl/srf_rx_status.sv
module srf_rx_status
   import serial_regfile_pkg::*;
#(
   parameter int unsigned W = CHAR_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic [W-1:0] rx_byte,
   input  logic [2:0]   rx_errs,    // {break, framing, parity}
   input  logic         rd_data,
   input  logic         rd_lsr,
   output logic [W-1:0] hold_q,
   output logic         dr_q,
   output logic         oe_q,
   output logic [2:0]   err_q
);

   logic ovr_now;

   // a character counts as overrun only if the holder stays occupied this cycle
   assign ovr_now = rx_valid & dr_q & ~rd_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         dr_q   <= 1'b0;
         oe_q   <= 1'b0;
         err_q  <= '0;
      end else begin
         if (rx_valid) begin
            hold_q <= rx_byte;
            dr_q   <= 1'b1;
         end else if (rd_data) begin
            dr_q   <= 1'b0;
         end
         oe_q  <= (oe_q & ~rd_lsr) | ovr_now;
         err_q <= (err_q & {3{~rd_lsr}}) | (rx_errs & {3{rx_valid}});
      end
   end

endmodule

// File: rtl/srf_modem_delta.sv
module srf_modem_delta
   import serial_regfile_pkg::*;
#(
   parameter int unsigned N    = MDM_N,
   parameter int unsigned RING = RING_IDX
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines_in,
   input  logic         rd_msr,
   output logic [N-1:0] state_q,
   output logic [N-1:0] delta_q
);

   generate
      if (RING >= N) begin : g_bad_ring
         $error("srf_modem_delta: RING must index a line");
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_line
      logic hit;
      if (i == RING) begin : g_trail
         assign hit = state_q[i] & ~lines_in[i];
      end else begin : g_any
         assign hit = state_q[i] ^ lines_in[i];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state_q[i] <= 1'b0;
            delta_q[i] <= 1'b0;
         end else begin
            state_q[i] <= lines_in[i];
            delta_q[i] <= (delta_q[i] & ~rd_msr) | hit;
         end
      end
   end

endmodule

// File: rtl/srf_irq_prio.sv
module srf_irq_prio
   import serial_regfile_pkg::*;
(
   input  logic [3:0] en,
   input  logic       line_err,
   input  logic       rx_ready_data,
   input  logic       thr_empty,
   input  logic       mdm_delta,
   output logic [2:0] iid,
   output logic       irq
);

   always_comb begin
      iid = ID_NONE;
      irq = 1'b0;
      if (line_err && en[EN_LINE]) begin
         iid = ID_LINE;
         irq = 1'b1;
      end else if (rx_ready_data && en[EN_RXD]) begin
         iid = ID_RXD;
         irq = 1'b1;
      end else if (thr_empty && en[EN_THR]) begin
         iid = ID_THR;
         irq = 1'b1;
      end else if (mdm_delta && en[EN_MDM]) begin
         iid = ID_MDM;
         irq = 1'b1;
      end
   end

endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
   import serial_regfile_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rx_perr,
   input  logic              rx_ferr,
   input  logic              rx_brk,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   input  logic              tx_hold_empty,
   input  logic              tx_line_idle,
   input  logic [3:0]        modem_lines,
   output logic [7:0]        cfg_lcr,
   output logic [1:0]        cfg_mcr,
   output logic [DIV_W-1:0]  cfg_div,
   output logic              irq
);

   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = 4;

   generate
      if (ADDR_W < IDX_HI + 1) begin : g_bad_addr
         $error("serial_regfile: ADDR_W too small for eight words");
      end
      if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad_div
         $error("serial_regfile: DIV_W out of range");
      end
   endgenerate

   // ---------------- decode ----------------
   logic  hit;
   word_e widx;
   logic  wr_data, rd_data, rd_lsr, rd_msr;
   logic  unused_wdata;

   assign hit     = (bus_addr[IDX_LO-1:0] == '0) && ((bus_addr >> (IDX_HI + 1)) == '0);
   assign widx    = word_e'(bus_addr[IDX_HI:IDX_LO]);
   assign wr_data = bus_wr & hit & (widx == W_DATA);
   assign rd_data = bus_rd & hit & (widx == W_DATA);
   assign rd_lsr  = bus_rd & hit & (widx == W_LSTAT);
   assign rd_msr  = bus_rd & hit & (widx == W_MSTAT);
   assign unused_wdata = ^bus_wdata;

   // ---------------- write-only settings and transmit ----------------
   logic [3:0] ier_q;
   logic       thre_q, temt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ier_q    <= '0;
         cfg_lcr  <= '0;
         cfg_mcr  <= '0;
         cfg_div  <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
         thre_q   <= 1'b1;
         temt_q   <= 1'b1;
      end else begin
         tx_valid <= wr_data;
         if (wr_data) tx_byte <= bus_wdata[7:0];
         if (bus_wr && hit) begin
            unique case (widx)
               W_IEN:   ier_q   <= bus_wdata[3:0];
               W_LCTL:  cfg_lcr <= bus_wdata[7:0];
               W_MCTL:  cfg_mcr <= bus_wdata[1:0];
               W_DIV:   cfg_div <= bus_wdata[DIV_W-1:0];
               default: ;
            endcase
         end
         thre_q <= tx_hold_empty;
         temt_q <= tx_line_idle;
      end
   end

   // ---------------- receive holder and line status ----------------
   logic [7:0] hold_q;
   logic       dr_q, oe_q;
   logic [2:0] err_q;
   logic [6:0] lsr_w;

   srf_rx_status #(.W(CHAR_W)) rx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .rx_errs  ({rx_brk, rx_ferr, rx_perr}),
      .rd_data  (rd_data),
      .rd_lsr   (rd_lsr),
      .hold_q   (hold_q),
      .dr_q     (dr_q),
      .oe_q     (oe_q),
      .err_q    (err_q)
   );

   assign lsr_w    = {temt_q, thre_q, err_q, oe_q, dr_q};
   assign rx_ready = ~dr_q;

   // ---------------- modem status ----------------
   logic [3:0] mdm_state, mdm_delta;

   srf_modem_delta #(.N(MDM_N), .RING(RING_IDX)) mdm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines_in (modem_lines),
      .rd_msr   (rd_msr),
      .state_q  (mdm_state),
      .delta_q  (mdm_delta)
   );

   // ---------------- interrupt ----------------
   logic [2:0] iid;

   srf_irq_prio prio_i (
      .en            (ier_q),
      .line_err      (oe_q | (|err_q)),
      .rx_ready_data (dr_q),
      .thr_empty     (thre_q),
      .mdm_delta     (|mdm_delta),
      .iid           (iid),
      .irq           (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (widx)
            W_DATA:  bus_rdata[7:0] = hold_q;
            W_IID:   bus_rdata[2:0] = iid;
            W_LSTAT: bus_rdata[6:0] = lsr_w;
            W_MSTAT: bus_rdata[7:0] = {mdm_state, mdm_delta};
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic              irq,
   input logic [6:0]        lsr_w,
   input logic [3:0]        ier_q
);

   logic       c_hit;
   logic [2:0] c_idx;
   logic       c_rd_data, c_rd_lsr, c_wr_data, c_rd_wo;

   assign c_hit     = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
   assign c_idx     = bus_addr[4:2];
   assign c_rd_data = bus_rd && c_hit && (c_idx == 3'd0);
   assign c_rd_lsr  = bus_rd && c_hit && (c_idx == 3'd5);
   assign c_wr_data = bus_wr && c_hit && (c_idx == 3'd0);
   assign c_rd_wo   = bus_rd && c_hit &&
                      (c_idx == 3'd1 || c_idx == 3'd3 || c_idx == 3'd4 || c_idx == 3'd7);

   AST_DR_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_data && !rx_valid |=> !lsr_w[0]); // R2

   AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && lsr_w[0] && !c_rd_data |=> lsr_w[1] && lsr_w[0]); // R3

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_ready); // R4

   AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_wo |-> bus_rdata == 32'd0); // R5

   AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(c_wr_data)); // R7

   AST_RXD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ier_q[0] && lsr_w[0] |-> irq); // R8

   AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ier_q == 4'd0 |-> !irq); // R8

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !c_rd_lsr |=> (lsr_w[4:1] & $past(lsr_w[4:1])) == $past(lsr_w[4:1])); // R9

endmodule

bind serial_regfile srf_checker #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .irq       (irq),
   .lsr_w     (lsr_w),
   .ier_q     (ier_q)
);

// File: tb/serial_regfile_tb_top.sv
module serial_regfile_tb_top;

   localparam int ADDR_W = 8;
   localparam int DIV_W  = 16;

   // byte addresses of the word slots
   localparam logic [7:0] A_DATA = 8'h00, A_IEN = 8'h04, A_IID = 8'h08, A_LCTL = 8'h0C,
                          A_MCTL = 8'h10, A_LST = 8'h14, A_MST = 8'h18, A_DIV = 8'h1C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_byte = '0;
   logic              rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
   logic              rx_ready, tx_valid, irq;
   logic [7:0]        tx_byte, cfg_lcr;
   logic              tx_hold_empty = 1'b1, tx_line_idle = 1'b1;
   logic [3:0]        modem_lines = '0;
   logic [1:0]        cfg_mcr;
   logic [DIV_W-1:0]  cfg_div;

   always #10 clk = ~clk;   // 50 MHz

   serial_regfile #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_hold_empty(tx_hold_empty),
      .tx_line_idle(tx_line_idle), .modem_lines(modem_lines), .cfg_lcr(cfg_lcr),
      .cfg_mcr(cfg_mcr), .cfg_div(cfg_div), .irq(irq)
   );

   typedef struct {
      logic [31:0] exp;
      logic [7:0]  addr;
      string       req;
   } sb_item_t;

   sb_item_t sb_q[$];
   sb_item_t cur;
   int n_cmp = 0;
   int n_bad = 0;

   // monitor: compares every read beat against the queued expectation
   always @(negedge clk) begin
      if (rst_n && bus_rd) begin
         if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read at %h: actual %h expected none", bus_addr, bus_rdata);
         end else begin
            cur = sb_q.pop_front();
            n_cmp++;
            if (bus_rdata !== cur.exp) begin
               n_bad++;
               $display("FAIL %s read %h: actual %h expected %h", cur.req, cur.addr, bus_rdata, cur.exp);
            end
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle, optionally with a read, a write and a character arrival
   task automatic cyc(input bit do_rd, input bit do_wr, input logic [7:0] addr,
                      input logic [31:0] val, input string req,
                      input bit do_rx, input logic [7:0] ch, input logic [2:0] errs);
      @(posedge clk); #1;
      if (do_rd) sb_q.push_back('{exp: val, addr: addr, req: req});
      bus_addr  = addr;
      bus_rd    = do_rd;
      bus_wr    = do_wr;
      bus_wdata = val;
      rx_valid  = do_rx;
      rx_byte   = ch;
      {rx_brk, rx_ferr, rx_perr} = errs;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_wr = 1'b0; rx_valid = 1'b0;
      {rx_brk, rx_ferr, rx_perr} = 3'b000;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
      cyc(1'b1, 1'b0, a, e, req, 1'b0, 8'h00, 3'b000);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b0, 1'b1, a, d, "", 1'b0, 8'h00, 3'b000);
   endtask

   task automatic rx(input logic [7:0] ch, input logic [2:0] errs);
      cyc(1'b0, 1'b0, 8'h00, 32'd0, "", 1'b1, ch, errs);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk({31'd0, irq}, 32'd0, "R1 irq after reset");
      chk({31'd0, rx_ready}, 32'd1, "R4 rx_ready after reset");
      rd(A_LST,  32'h60, "R1 line status");
      rd(A_IID,  32'h01, "R1 identification");
      rd(A_DATA, 32'h00, "R1 data");
      rd(A_MST,  32'h00, "R1 modem status");

      // R8 transmit-empty cause alone
      wr(A_IEN, 32'h2);
      chk({31'd0, irq}, 32'd1, "R8 irq on transmit empty");
      rd(A_IID, 32'h02, "R8 code transmit empty");
      wr(A_IEN, 32'h0);
      chk({31'd0, irq}, 32'd0, "R8 irq off without enable");

      // R5 write-only settings
      wr(A_LCTL, 32'hFFFF_FF1B);
      wr(A_MCTL, 32'h0000_0003);
      wr(A_DIV,  32'hABCD_1234);
      chk({24'd0, cfg_lcr}, 32'h1B, "R5 line control out");
      chk({30'd0, cfg_mcr}, 32'h3, "R5 modem control out");
      chk({16'd0, cfg_div}, 32'h1234, "R5 divisor out");
      rd(A_LCTL, 32'h0, "R5 line control reads zero");
      rd(A_MCTL, 32'h0, "R5 modem control reads zero");
      rd(A_DIV,  32'h0, "R5 divisor reads zero");
      rd(A_IEN,  32'h0, "R5 enable reads zero");

      // R6 writes to read-only words
      wr(A_LST, 32'hFF);
      wr(A_IID, 32'hFF);
      wr(A_MST, 32'hFF);
      rd(A_LST, 32'h60, "R6 line status unchanged");
      rd(A_IID, 32'h01, "R6 identification unchanged");
      rd(A_MST, 32'h00, "R6 modem status unchanged");

      // R7 transmit pulse
      wr(A_DATA, 32'h0000_01A5);
      chk({31'd0, tx_valid}, 32'd1, "R7 tx pulse high");
      chk({24'd0, tx_byte}, 32'hA5, "R7 tx byte");
      @(posedge clk); #1;
      chk({31'd0, tx_valid}, 32'd0, "R7 tx pulse one cycle");

      // R2 / R4 single character
      rx(8'h3C, 3'b000);
      chk({31'd0, rx_ready}, 32'd0, "R4 rx_ready low when held");
      rd(A_LST,  32'h61, "R2 data ready set");
      rd(A_DATA, 32'h3C, "R2 data returned");
      rd(A_LST,  32'h60, "R2 data ready cleared");
      chk({31'd0, rx_ready}, 32'd1, "R4 rx_ready back high");

      // R3 overrun
      rx(8'h11, 3'b000);
      rx(8'h22, 3'b000);
      rd(A_LST,  32'h63, "R3 overrun flag");
      rd(A_DATA, 32'h22, "R3 newest character kept");
      rd(A_LST,  32'h60, "R9 overrun cleared by status read");

      // R3 arrival in the same cycle as a data read
      rx(8'h44, 3'b000);
      cyc(1'b1, 1'b0, A_DATA, 32'h44, "R3 read beside arrival", 1'b1, 8'h55, 3'b000);
      rd(A_LST,  32'h61, "R3 no overrun when read coincides");
      rd(A_DATA, 32'h55, "R3 coinciding character held");

      // R8 priority ladder
      wr(A_IEN, 32'hF);
      rd(A_IID, 32'h02, "R8 transmit empty only");
      rx(8'h77, 3'b010);
      rd(A_IID, 32'h06, "R8 line error wins");
      rd(A_LST, 32'h69, "R9 framing flag set");
      rd(A_IID, 32'h04, "R8 data ready next");
      rd(A_DATA, 32'h77, "R2 errored character");
      rd(A_IID, 32'h02, "R8 transmit empty next");
      tx_hold_empty = 1'b0; tx_line_idle = 1'b0;
      rd(A_IID, 32'h01, "R8 no cause");
      rd(A_LST, 32'h00, "R11 transmitter status followed");
      modem_lines = 4'b0001;
      rd(A_IID, 32'h00, "R8 modem cause");
      chk({31'd0, irq}, 32'd1, "R8 irq on modem cause");
      rd(A_MST, 32'h11, "R10 CTS change delta");
      rd(A_IID, 32'h01, "R10 delta cleared by read");
      chk({31'd0, irq}, 32'd0, "R8 irq off with no cause");
      modem_lines = 4'b0101;
      rd(A_MST, 32'h50, "R10 ring rise gives no delta");
      modem_lines = 4'b0001;
      rd(A_MST, 32'h14, "R10 ring fall delta");
      rd(A_MST, 32'h10, "R10 ring delta cleared");
      tx_hold_empty = 1'b1; tx_line_idle = 1'b1;
      wr(A_IEN, 32'h0);
      rd(A_LST, 32'h60, "R11 transmitter status restored");

      // R9 error arrival in the same cycle as a status read
      cyc(1'b1, 1'b0, A_LST, 32'h60, "R9 read beside error arrival", 1'b1, 8'h5A, 3'b001);
      rd(A_LST, 32'h65, "R9 parity flag survives read");
      rd(A_LST, 32'h61, "R9 parity cleared by next read");
      rd(A_DATA, 32'h5A, "R2 parity character");
      rx(8'h00, 3'b100);
      rd(A_LST, 32'h71, "R9 break flag");
      rd(A_DATA, 32'h00, "R2 break character");
      rd(A_LST, 32'h60, "R9 break cleared");

      @(posedge clk); #1;
      if (sb_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule